// File: doc/BRIEF.md
# Single-Accumulator Instruction Sequencer

This block is the control unit of a small stored-program machine built around one working register, the accumulator. It owns the program counter, the instruction register, the memory address register and the memory data register. It walks each instruction through fetch, decode and execute phases as a fixed sequence of single-cycle register transfers. It drives a word-wide memory through one address port, a read strobe, a write strobe and a write-data port.

Arithmetic and comparison are done by an external ALU. The sequencer presents the memory data register and the accumulator as the two operands, selects the operation, and either takes the result back into the accumulator or latches the three magnitude flags. Conditional branches test the latched flags. Execution runs from address zero after reset and continues until a halt, or an unknown opcode, parks the sequencer.

Top module: `accum_sequencer`

## Requirements
- R1: After reset the sequencer is not halted, asserts neither memory strobe, and holds the program counter, the accumulator and all three flags at zero, so the first instruction is read from address 0.
- R2: An instruction fetch puts the program counter on `mem_addr` and pulses `mem_rd` for one cycle. It takes `mem_rdata` in the cycle after the strobe, moves it to the instruction register, and then adds one to the program counter, so instructions run in address order.
- R3: An instruction word is 16 bits. Bits [15:12] hold the opcode and bits [11:0] hold the address X. The opcodes are 0x0 LOAD, 0x1 STORE, 0x3 ADD, 0x4 COMPARE, 0x5 JUMP, 0x6 JUMP-IF-GT, 0x7 JUMP-IF-EQ, 0x8 JUMP-IF-LT and 0xF HALT.
- R4: LOAD X reads the word at X, with the same one-cycle read latency, and places it in the accumulator.
- R5: STORE X writes the accumulator to address X with a single-cycle `mem_wr` pulse, `mem_wdata` carrying the value.
- R6: ADD X reads the word at X and drives `alu_op` = 2'b01 for one cycle with `alu_a` holding that word and `alu_b` holding the accumulator. The accumulator then takes `alu_result`, which wraps modulo 2^16.
- R7: COMPARE X reads the word at X and drives `alu_op` = 2'b10 for one cycle with `alu_a` = word and `alu_b` = accumulator. It latches `alu_gt`, `alu_eq` and `alu_lt`, where GT means the word at X is greater than the accumulator. The accumulator is left unchanged.
- R8: JUMP X sets the program counter to X unconditionally.
- R9: A conditional jump sets the program counter to X only when its flag (GT for 0x6, EQ for 0x7, LT for 0x8) is set. Otherwise the next instruction is the one after it.
- R10: HALT, and any opcode not listed in R3, raises `halted`, which then stays high with no further memory strobes until reset.
- R11: `mem_rd` and `mem_wr` are never asserted in the same cycle, and neither is high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Memory address (the memory address register) |
| mem_rd | output | 1 | Read strobe; data is expected one cycle later |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data (the memory data register) |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd` |
| alu_op | output | 2 | 00 idle, 01 add, 10 compare |
| alu_a | output | 16 | ALU operand: fetched memory word |
| alu_b | output | 16 | ALU operand: accumulator |
| alu_result | input | 16 | ALU sum |
| alu_gt | input | 1 | ALU flag: operand a greater than b |
| alu_eq | input | 1 | ALU flag: operands equal |
| alu_lt | input | 1 | ALU flag: operand a less than b |
| halted | output | 1 | High once a halt or unknown opcode has executed |

## Verification
The bench builds the sequencer with its default 16-bit word, 4-bit opcode and 12-bit address. This gives the full 4096-word memory model and puts the carry-wrapping sums at 0xFFFF within reach. One branching program is run against a table of operand pairs, so every compare outcome sends control through taken and not-taken conditional jumps and an unconditional jump before a sum is stored. Directed runs cover the cleared flags and accumulator after reset, and an undefined opcode parking the machine with its strobe count frozen.

// File: rtl/accum_pkg.sv
package accum_pkg;

   typedef enum logic [3:0] {
      OPC_LOAD  = 4'h0,
      OPC_STORE = 4'h1,
      OPC_ADD   = 4'h3,
      OPC_CMP   = 4'h4,
      OPC_JMP   = 4'h5,
      OPC_JGT   = 4'h6,
      OPC_JEQ   = 4'h7,
      OPC_JLT   = 4'h8,
      OPC_HALT  = 4'hF
   } opcode_e;

   typedef enum logic [1:0] {
      ALU_IDLE = 2'b00,
      ALU_ADD  = 2'b01,
      ALU_CMP  = 2'b10
   } alu_sel_e;

   typedef enum logic [2:0] {
      K_LOAD, K_STORE, K_ADD, K_CMP, K_JUMP, K_COND, K_STOP
   } instr_kind_e;

   typedef enum logic [3:0] {
      PH_IADDR, PH_IREQ, PH_ICAP, PH_ILATCH, PH_DECODE,
      PH_OADDR, PH_OREQ, PH_OCAP, PH_EXEC,
      PH_SDATA, PH_SWRITE, PH_PARK
   } phase_e;

   typedef struct packed {
      logic gt;
      logic eq;
      logic lt;
   } cmp_flags_t;

endpackage

// File: rtl/accum_decoder.sv
module accum_decoder
   import accum_pkg::*;
#(
   parameter int OP_W = 4
) (
   input  logic [OP_W-1:0] opcode,
   output instr_kind_e     kind,
   output cmp_flags_t      cond_mask
);

   generate
      if (OP_W != 4) begin : g_bad_opw
         $error("accum_decoder: opcode field must be 4 bits");
      end
   endgenerate

   always_comb begin
      kind      = K_STOP;
      cond_mask = '0;
      case (opcode)
         OPC_LOAD:  kind = K_LOAD;
         OPC_STORE: kind = K_STORE;
         OPC_ADD:   kind = K_ADD;
         OPC_CMP:   kind = K_CMP;
         OPC_JMP:   kind = K_JUMP;
         OPC_JGT: begin
            kind      = K_COND;
            cond_mask = '{gt: 1'b1, eq: 1'b0, lt: 1'b0};
         end
         OPC_JEQ: begin
            kind      = K_COND;
            cond_mask = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};
         end
         OPC_JLT: begin
            kind      = K_COND;
            cond_mask = '{gt: 1'b0, eq: 1'b0, lt: 1'b1};
         end
         default:   kind = K_STOP;   // HALT and every unlisted code
      endcase
   end

   // R9: a conditional jump tests exactly one flag
   always_comb begin
      a_r9_one_flag_tested: assert ($onehot0(cond_mask));
   end

endmodule

// File: rtl/accum_pc.sv
module accum_pc #(
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              load,
   input  logic [ADDR_W-1:0] target,
   output logic [ADDR_W-1:0] pc
);

   generate
      if (ADDR_W < 2) begin : g_bad_aw
         $error("accum_pc: address width too small");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         pc <= '0;
      else if (load)
         pc <= target;
      else if (step)
         pc <= pc + 1'b1;
   end

   a_r2_pc_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> pc == $past(pc) + 1'b1);

   a_r2_pc_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> $stable(pc));

   a_r8_no_step_and_load: assert property (@(posedge clk) disable iff (!rst_n)
      !(step && load));

endmodule

// File: rtl/accum_flags.sv
module accum_flags
   import accum_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       capture,
   input  cmp_flags_t d,
   output cmp_flags_t q
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (capture)
         q <= d;
   end

   a_r7_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(q));

   a_r7_flags_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(q));

endmodule

// File: rtl/accum_sequencer.sv
module accum_sequencer
   import accum_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int OP_W   = 4,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [1:0]        alu_op,
   output logic [DATA_W-1:0] alu_a,
   output logic [DATA_W-1:0] alu_b,
   input  logic [DATA_W-1:0] alu_result,
   input  logic              alu_gt,
   input  logic              alu_eq,
   input  logic              alu_lt,
   output logic              halted
);

   localparam int OP_LSB = DATA_W - OP_W;

   generate
      if (DATA_W != OP_W + ADDR_W) begin : g_bad_split
         $error("accum_sequencer: word must be opcode plus address");
      end
   endgenerate

   phase_e            phase;
   logic [ADDR_W-1:0] mar;
   logic [DATA_W-1:0] mdr;
   logic [DATA_W-1:0] ir;
   logic [DATA_W-1:0] acc;
   logic [ADDR_W-1:0] pc;
   instr_kind_e       kind;
   cmp_flags_t        cond_mask;
   cmp_flags_t        flags_q;
   cmp_flags_t        flags_d;
   logic              pc_step;
   logic              pc_load;
   logic              taken;
   logic              cmp_cap;

   wire [OP_W-1:0]   ir_op   = ir[DATA_W-1:OP_LSB];
   wire [ADDR_W-1:0] ir_addr = ir[ADDR_W-1:0];

   accum_decoder #(.OP_W(OP_W)) u_dec (
      .opcode    (ir_op),
      .kind      (kind),
      .cond_mask (cond_mask)
   );

   assign taken   = |(cond_mask & flags_q);
   assign pc_step = (phase == PH_ILATCH);
   assign pc_load = (phase == PH_DECODE) &&
                    ((kind == K_JUMP) || ((kind == K_COND) && taken));

   accum_pc #(.ADDR_W(ADDR_W)) u_pc (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (pc_step),
      .load   (pc_load),
      .target (ir_addr),
      .pc     (pc)
   );

   assign cmp_cap = (phase == PH_EXEC) && (kind == K_CMP);
   assign flags_d = '{gt: alu_gt, eq: alu_eq, lt: alu_lt};

   accum_flags u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (cmp_cap),
      .d       (flags_d),
      .q       (flags_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IADDR;
         mar   <= '0;
         mdr   <= '0;
         ir    <= '0;
         acc   <= '0;
      end else begin
         case (phase)
            PH_IADDR: begin
               mar   <= pc;
               phase <= PH_IREQ;
            end
            PH_IREQ:  phase <= PH_ICAP;
            PH_ICAP: begin
               mdr   <= mem_rdata;
               phase <= PH_ILATCH;
            end
            PH_ILATCH: begin
               ir    <= mdr;
               phase <= PH_DECODE;
            end
            PH_DECODE: begin
               case (kind)
                  K_LOAD, K_STORE, K_ADD, K_CMP: phase <= PH_OADDR;
                  K_JUMP, K_COND:                phase <= PH_IADDR;
                  default:                       phase <= PH_PARK;
               endcase
            end
            PH_OADDR: begin
               mar   <= ir_addr;
               phase <= (kind == K_STORE) ? PH_SDATA : PH_OREQ;
            end
            PH_OREQ:  phase <= PH_OCAP;
            PH_OCAP: begin
               mdr   <= mem_rdata;
               phase <= PH_EXEC;
            end
            PH_EXEC: begin
               if (kind == K_LOAD)
                  acc <= mdr;
               else if (kind == K_ADD)
                  acc <= alu_result;
               phase <= PH_IADDR;
            end
            PH_SDATA: begin
               mdr   <= acc;
               phase <= PH_SWRITE;
            end
            PH_SWRITE: phase <= PH_IADDR;
            default:   phase <= PH_PARK;
         endcase
      end
   end

   always_comb begin
      alu_op = ALU_IDLE;
      if (phase == PH_EXEC) begin
         if (kind == K_ADD)
            alu_op = ALU_ADD;
         else if (kind == K_CMP)
            alu_op = ALU_CMP;
      end
   end

   assign mem_addr  = mar;
   assign mem_wdata = mdr;
   assign mem_rd    = (phase == PH_IREQ) || (phase == PH_OREQ);
   assign mem_wr    = (phase == PH_SWRITE);
   assign alu_a     = mdr;
   assign alu_b     = acc;
   assign halted    = (phase == PH_PARK);

   a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   a_r11_rd_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd);

   a_r11_wr_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> !mem_wr);

   a_r10_park_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halted && !mem_rd && !mem_wr));

   a_r5_store_carries_acc: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> mem_wdata == acc);

   a_r6_add_writes_back: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_op == ALU_ADD) |=> acc == $past(alu_result));

   a_r7_compare_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_op == ALU_CMP) |=> $stable(acc));

   a_r2_rd_then_capture: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_wr && !halted);

endmodule

// File: tb/accum_sequencer_test.sv
module accum_sequencer_test;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 6;
   // {operand a at 0x100, operand b at 0x101, expected word at 0x120}
   localparam logic [47:0] VEC [NVEC] = '{
      48'h0005_0009_000A,   // b > a : 1 + 9
      48'h0007_0007_0009,   // equal : 2 + 7
      48'h0009_0004_0007,   // b < a : 3 + 4
      48'h0000_FFFF_0000,   // b > a, sum wraps
      48'hFFFF_FFFF_0001,   // equal at top, sum wraps
      48'h8000_7FFF_8002    // b < a across bit 15
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] mem_addr;
   logic        mem_rd, mem_wr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata;
   logic [1:0]  alu_op;
   logic [15:0] alu_a, alu_b;
   logic [15:0] alu_result;
   logic        alu_gt, alu_eq, alu_lt;
   logic        halted;

   logic [15:0] mem [4096];
   int          checks = 0;
   int          failures = 0;
   int          rd_count = 0;
   logic [11:0] first_rd_addr = '0;
   logic        seen_rd = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   accum_sequencer uut (
      .clk(clk), .rst_n(rst_n),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b),
      .alu_result(alu_result),
      .alu_gt(alu_gt), .alu_eq(alu_eq), .alu_lt(alu_lt),
      .halted(halted)
   );

   // memory model: read data appears the cycle after the strobe
   always @(posedge clk) begin
      if (mem_wr) mem[mem_addr] <= mem_wdata;
      if (mem_rd) mem_rdata <= mem[mem_addr];
   end

   // ALU model: answers only the operation it is asked for
   always_comb begin
      alu_result = (alu_op == 2'b01) ? alu_a + alu_b : 16'h0000;
      alu_gt = (alu_op == 2'b10) && (alu_a >  alu_b);
      alu_eq = (alu_op == 2'b10) && (alu_a == alu_b);
      alu_lt = (alu_op == 2'b10) && (alu_a <  alu_b);
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         rd_count <= 0;
         seen_rd  <= 1'b0;
      end else if (mem_rd) begin
         rd_count <= rd_count + 1;
         if (!seen_rd) first_rd_addr <= mem_addr;
         seen_rd <= 1'b1;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
      mem_rdata = 16'h0000;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_to_halt(input string req);
      int n = 0;
      while (!halted && n < 3000) begin
         @(negedge clk);
         n++;
      end
      check({req, " halted"}, {31'd0, halted}, 32'd1);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      // R1: reset state and flags/accumulator cleared
      clear_mem();
      mem[0] = 16'h6005;   // JGT 5
      mem[1] = 16'h7005;   // JEQ 5
      mem[2] = 16'h8005;   // JLT 5
      mem[3] = 16'h1130;   // STORE 0x130
      mem[4] = 16'hF000;   // HALT
      mem[5] = 16'h1131;   // STORE 0x131 (only if a jump is wrongly taken)
      mem[6] = 16'hF000;
      mem[12'h130] = 16'hFFFF;
      mem[12'h131] = 16'hAAAA;
      do_reset();
      check("R1 halted low", {31'd0, halted}, 32'd0);
      check("R1 no strobes", {30'd0, mem_rd, mem_wr}, 32'd0);
      run_to_halt("R9");
      check("R1 first fetch at 0", {20'd0, first_rd_addr}, 32'd0);
      check("R1 accumulator zero", {16'd0, mem[12'h130]}, 32'h0000);
      check("R9 no jump on clear flags", {16'd0, mem[12'h131]}, 32'hAAAA);

      // table of branching programs: R3 R4 R5 R6 R7 R8 R9
      for (int v = 0; v < NVEC; v++) begin
         clear_mem();
         mem[0]  = 16'h0100;   // LOAD a
         mem[1]  = 16'h4101;   // COMPARE b
         mem[2]  = 16'h6006;   // JGT 6
         mem[3]  = 16'h7008;   // JEQ 8
         mem[4]  = 16'h800A;   // JLT 10
         mem[5]  = 16'hF000;
         mem[6]  = 16'h0110;   // LOAD 1
         mem[7]  = 16'h500B;   // JUMP 11
         mem[8]  = 16'h0111;   // LOAD 2
         mem[9]  = 16'h500B;   // JUMP 11
         mem[10] = 16'h0112;   // LOAD 3
         mem[11] = 16'h3101;   // ADD b
         mem[12] = 16'h1120;   // STORE 0x120
         mem[13] = 16'hF000;
         mem[12'h100] = VEC[v][47:32];
         mem[12'h101] = VEC[v][31:16];
         mem[12'h110] = 16'd1;
         mem[12'h111] = 16'd2;
         mem[12'h112] = 16'd3;
         mem[12'h120] = 16'hDEAD;
         do_reset();
         run_to_halt("R10");
         check($sformatf("R7 R6 vector %0d stored sum", v),
               {16'd0, mem[12'h120]}, {16'd0, VEC[v][15:0]});
      end

      // R10: undefined opcode parks the sequencer
      clear_mem();
      mem[0] = 16'h0100;   // LOAD 0x100
      mem[1] = 16'hA000;   // unlisted opcode
      mem[2] = 16'h1130;   // STORE (must not run)
      mem[3] = 16'hF000;
      mem[12'h100] = 16'h1234;
      mem[12'h130] = 16'h5555;
      do_reset();
      run_to_halt("R10 unknown opcode");
      check("R10 read strobes at park", rd_count, 32'd3);
      repeat (20) @(negedge clk);
      check("R10 still halted", {31'd0, halted}, 32'd1);
      check("R10 no strobes after park", rd_count, 32'd3);
      check("R10 store skipped", {16'd0, mem[12'h130]}, 32'h5555);

      // R2 R4 R5: sequential load/store, read latency of one cycle
      clear_mem();
      mem[0] = 16'h0200;   // LOAD 0x200
      mem[1] = 16'h1201;   // STORE 0x201
      mem[2] = 16'h0202;   // LOAD 0x202
      mem[3] = 16'h1203;   // STORE 0x203
      mem[4] = 16'hF000;
      mem[12'h200] = 16'hC3A5;
      mem[12'h202] = 16'h0F0F;
      do_reset();
      run_to_halt("R2");
      check("R4 R5 first copy", {16'd0, mem[12'h201]}, 32'hC3A5);
      check("R4 R5 second copy", {16'd0, mem[12'h203]}, 32'h0F0F);
      check("R2 read count", rd_count, 32'd7);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule